// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block paces a UART. From the functional clock it derives a one-cycle sample strobe at the oversampling rate and a bit strobe once per serial bit period. The input clock first passes through an integer prescaler with a ratio from 1 to 8. A fractional divider follows it, with a 16-bit whole part and a 6-bit fraction counted in 64ths. The divider sets the spacing of the sample strobes. A group counter then turns every N sample strobes into one bit strobe, where N is 16, 8 or 3.

Software computes the divisor and prescaler values for the target baud rate and loads them on the inputs. The block copies its settings only while it is disabled, so changing them on a running link has no effect until the next enable. When the whole divisor part is zero, the block gives no strobes at all. Three-times oversampling cannot work with an encoded line format, so the 3x setting is promoted to 8x whenever the encoded-line input is high.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and while `en_i` is low, `sample_tick_o` and `bit_tick_o` are both low.
- R2: If the latched whole divisor is 0, the block gives no sample or bit strobes, whatever fraction is loaded.
- R3: With a fraction of 0, consecutive sample strobes are exactly P*I clock cycles apart. P is the prescale ratio and I is the whole divisor.
- R4: With fraction F, each gap between sample strobes is either P*I or P*(I+1) cycles, and any 64 consecutive gaps add up to exactly P*(64*I+F). For example, I=130, F=13, P=1 gives 8333 cycles per 64 samples.
- R5: A `prescale_i` code of k divides the clock by k+1, so codes 0 to 7 give ratios 1 to 8.
- R6: `bit_tick_o` is high only together with `sample_tick_o`, on the sample strobe that completes each group of N. The `ovs_sel_i` codes are 2'b00 for 16, 2'b01 for 8, 2'b10 for 3 and 2'b11 for 16.
- R7: With `coded_line_i` high at the time of latching, the code 2'b10 gives N=8 instead of 3.
- R8: The prescale, divisor, fraction, oversampling and encoded-line inputs are latched only while `en_i` is low. A change made while enabled takes effect only after the next disable and enable.
- R9: Dropping `en_i` stops both strobes in that same cycle. After re-enabling, the first bit strobe comes on the Nth sample strobe, because the group count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; settings are latched while low |
| prescale_i | input | 3 | Prescale ratio minus one |
| int_div_i | input | 16 | Whole part of the divisor |
| frac_div_i | input | 6 | Fractional part of the divisor, in 64ths |
| ovs_sel_i | input | 2 | Oversampling code (00=16, 01=8, 10=3, 11=16) |
| coded_line_i | input | 1 | Encoded line format active; promotes 3x to 8x |
| sample_tick_o | output | 1 | One-cycle strobe at the oversampling rate |
| bit_tick_o | output | 1 | One-cycle strobe once per bit period |

## Verification
The fraction is checked by adding up 64 consecutive gaps at the datasheet-style point of 130 plus 13/64 and at a half-step setting. A design that drops the carry, or applies it on every period, misses the 8333-cycle total. Prescaler codes 0 and 7 are measured directly, which exposes an off-by-one in the ratio. The group length is counted for every oversampling code, including 3x with and without an encoded line, so a missing promotion shows up as a group of 3. Settings changed while running must leave the gap unchanged until a re-enable, and a zero whole divisor with a nonzero fraction must stay silent. A design that latches settings all the time, or that lets the fraction tick on its own, fails these checks.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 6;
  localparam int PRE_W  = 3;
  localparam int GRP_W  = 4;

  typedef enum logic [1:0] {
    OVS_16  = 2'b00,
    OVS_8   = 2'b01,
    OVS_3   = 2'b10,
    OVS_RSV = 2'b11
  } ovs_e;

  typedef struct packed {
    logic [PRE_W-1:0]  pre;
    logic [INT_W-1:0]  ibrd;
    logic [FRAC_W-1:0] fbrd;
    logic [GRP_W-1:0]  last;  // group length minus one
  } baud_cfg_t;

  function automatic logic [GRP_W-1:0] ovs_last(input logic [1:0] sel, input logic coded);
    case (ovs_e'(sel))
      OVS_8:   ovs_last = GRP_W'(7);
      OVS_3:   ovs_last = coded ? GRP_W'(7) : GRP_W'(2);
      default: ovs_last = GRP_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/baud_cfg_latch.sv
module baud_cfg_latch
  import baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [INT_W-1:0]  ibrd_i,
  input  logic [FRAC_W-1:0] fbrd_i,
  input  logic [1:0]        ovs_i,
  input  logic              coded_i,
  output baud_cfg_t         cfg_o
);
  baud_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (!en_i) begin
      cfg_q.pre  <= pre_i;
      cfg_q.ibrd <= ibrd_i;
      cfg_q.fbrd <= fbrd_i;
      cfg_q.last <= ovs_last(ovs_i, coded_i);
    end
  end

  assign cfg_o = cfg_q;

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(cfg_q));

  assert_coded_promote_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && ovs_i == 2'b10 && coded_i) |=> (cfg_q.last == GRP_W'(7)));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int PRE_W = baud_pkg::PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] ratio_i,  // divide by ratio_i + 1
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == ratio_i);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || wrap)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assert_pre_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && ratio_i != '0 && $stable(ratio_i)) |=> !tick_o);
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int INT_W  = baud_pkg::INT_W,
  parameter int FRAC_W = baud_pkg::FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              step_i,
  input  logic [INT_W-1:0]  ibrd_i,
  input  logic [FRAC_W-1:0] fbrd_i,
  output logic              tick_o
);
  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              stretch_q;
  logic [INT_W:0]    end_val;
  logic [FRAC_W:0]   acc_sum;
  logic              last;

  // a long period holds one extra prescaled step
  assign end_val = {1'b0, ibrd_i} + {{INT_W{1'b0}}, stretch_q} - 1'b1;
  assign acc_sum = {1'b0, acc_q} + {1'b0, fbrd_i};
  assign last    = ({1'b0, cnt_q} == end_val);
  assign tick_o  = run_i && step_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (step_i) begin
      if (last) begin
        cnt_q     <= '0;
        acc_q     <= acc_sum[FRAC_W-1:0];
        stretch_q <= acc_sum[FRAC_W];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_stretch_needs_frac_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && fbrd_i == '0 && $past(run_i) && $stable(fbrd_i) && $past(fbrd_i) == '0
     && $past(stretch_q) == 1'b0) |-> !stretch_q);
endmodule

// File: rtl/baud_bit_group.sv
module baud_bit_group #(
  parameter int GRP_W = baud_pkg::GRP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             smp_i,
  input  logic [GRP_W-1:0] last_i,
  output logic             bit_o
);
  logic [GRP_W-1:0] grp_q;

  assign bit_o = smp_i && (grp_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      grp_q <= '0;
    else if (!run_i)  grp_q <= '0;
    else if (bit_o)   grp_q <= '0;
    else if (smp_i)   grp_q <= grp_q + 1'b1;
  end

  assert_bit_on_sample_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> smp_i);

  assert_grp_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $stable(last_i)) |-> (grp_q <= last_i));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [INT_W-1:0]  int_div_i,
  input  logic [FRAC_W-1:0] frac_div_i,
  input  logic [1:0]        ovs_sel_i,
  input  logic              coded_line_i,
  output logic              sample_tick_o,
  output logic              bit_tick_o
);
  baud_cfg_t cfg;
  logic      run;
  logic      pre_tick;
  logic      smp;
  logic      bit_t;

  baud_cfg_latch u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .pre_i   (prescale_i),
    .ibrd_i  (int_div_i),
    .fbrd_i  (frac_div_i),
    .ovs_i   (ovs_sel_i),
    .coded_i (coded_line_i),
    .cfg_o   (cfg)
  );

  // zero whole divisor inhibits everything
  assign run = en_i && (cfg.ibrd != '0);

  baud_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .ratio_i (cfg.pre),
    .tick_o  (pre_tick)
  );

  baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .step_i (pre_tick),
    .ibrd_i (cfg.ibrd),
    .fbrd_i (cfg.fbrd),
    .tick_o (smp)
  );

  baud_bit_group #(.GRP_W(GRP_W)) u_grp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .smp_i  (smp),
    .last_i (cfg.last),
    .bit_o  (bit_t)
  );

  assign sample_tick_o = smp;
  assign bit_tick_o    = bit_t;

  assert_no_tick_zero_div_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.ibrd == '0) |-> (!sample_tick_o && !bit_tick_o));

  assert_idle_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!sample_tick_o && !bit_tick_o));
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [2:0]  prescale_i = '0;
  logic [15:0] int_div_i = '0;
  logic [5:0]  frac_div_i = '0;
  logic [1:0]  ovs_sel_i = '0;
  logic        coded_line_i = 1'b0;
  logic        sample_tick_o;
  logic        bit_tick_o;

  int total = 0;
  int bad = 0;
  localparam int LIMIT = 4000;

  always #2.5 clk_i = ~clk_i;

  baud_tick_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .prescale_i(prescale_i),
    .int_div_i(int_div_i), .frac_div_i(frac_div_i), .ovs_sel_i(ovs_sel_i),
    .coded_line_i(coded_line_i), .sample_tick_o(sample_tick_o), .bit_tick_o(bit_tick_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int pre, input int idiv, input int fdiv, input int ovs, input bit coded);
    en_i = 1'b0;
    @(negedge clk_i);
    prescale_i = 3'(pre);
    int_div_i = 16'(idiv);
    frac_div_i = 6'(fdiv);
    ovs_sel_i = 2'(ovs);
    coded_line_i = coded;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic gap(output int g);
    int c = 0;
    do begin
      @(negedge clk_i);
      c++;
    end while (!sample_tick_o && c < LIMIT);
    g = c;
  endtask

  task automatic group_len(output int n, output int stray);
    int c = 0;
    int k = 0;
    stray = 0;
    do begin
      @(negedge clk_i);
      k++;
      if (sample_tick_o) c++;
      if (bit_tick_o && !sample_tick_o) stray++;
    end while (!bit_tick_o && k < LIMIT);
    n = c;
  endtask

  task automatic t_reset();
    int seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (sample_tick_o || bit_tick_o) seen++;
    end
    chk(seen == 0, "R1 reset idle", seen, 0);
  endtask

  task automatic t_zero_div();
    int seen = 0;
    setup(0, 0, 40, 0, 1'b0);
    en_i = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk_i);
      if (sample_tick_o || bit_tick_o) seen++;
    end
    chk(seen == 0, "R2 zero divisor silent", seen, 0);
  endtask

  task automatic t_integer(input int pre, input int idiv, input string req);
    int g;
    setup(pre, idiv, 0, 0, 1'b0);
    en_i = 1'b1;
    gap(g);
    for (int i = 0; i < 3; i++) begin
      gap(g);
      chk(g == (pre + 1) * idiv, req, g, (pre + 1) * idiv);
    end
  endtask

  task automatic t_frac(input int pre, input int idiv, input int fdiv);
    int g;
    int sum = 0;
    int odd = 0;
    int p = pre + 1;
    setup(pre, idiv, fdiv, 0, 1'b0);
    en_i = 1'b1;
    gap(g);
    for (int i = 0; i < 64; i++) begin
      gap(g);
      sum += g;
      if (g != p * idiv && g != p * (idiv + 1)) odd++;
    end
    chk(odd == 0, "R4 gap is short or long", odd, 0);
    chk(sum == p * (64 * idiv + fdiv), "R4 64-gap total", sum, p * (64 * idiv + fdiv));
  endtask

  task automatic t_group(input int ovs, input bit coded, input int n_exp, input string req);
    int n;
    int stray;
    setup(0, 2, 0, ovs, coded);
    en_i = 1'b1;
    for (int i = 0; i < 2; i++) begin
      group_len(n, stray);
      chk(n == n_exp, req, n, n_exp);
      chk(stray == 0, "R6 bit strobe without sample", stray, 0);
    end
  endtask

  task automatic t_latch();
    int g;
    setup(0, 3, 0, 0, 1'b0);
    en_i = 1'b1;
    gap(g);
    int_div_i = 16'd7;
    prescale_i = 3'd5;
    gap(g);
    gap(g);
    chk(g == 3, "R8 running ignores new divisor", g, 3);
    int_div_i = 16'd0;
    gap(g);
    chk(g == 3, "R8 running ignores zero divisor", g, 3);
    int_div_i = 16'd7;
    prescale_i = 3'd0;
    en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    en_i = 1'b1;
    gap(g);
    gap(g);
    chk(g == 7, "R8 re-enable picks up divisor", g, 7);
  endtask

  task automatic t_disable();
    int seen = 0;
    int n;
    int stray;
    int g;
    setup(0, 2, 0, 1, 1'b0);
    en_i = 1'b1;
    for (int i = 0; i < 3; i++) gap(g);
    en_i = 1'b0;
    #0.1;
    if (sample_tick_o || bit_tick_o) seen++;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (sample_tick_o || bit_tick_o) seen++;
    end
    chk(seen == 0, "R9 disable stops strobes", seen, 0);
    en_i = 1'b1;
    group_len(n, stray);
    chk(n == 8, "R9 group restarts after enable", n, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(sample_tick_o == 1'b0 && bit_tick_o == 1'b0, "R1 outputs in reset",
        int'(sample_tick_o) + int'(bit_tick_o), 0);
    rst_ni = 1'b1;
    t_reset();
    t_zero_div();
    t_integer(0, 5, "R3 integer gap");
    t_integer(2, 5, "R5 prescale code 2");
    t_integer(0, 3, "R5 prescale code 0");
    t_integer(7, 3, "R5 prescale code 7");
    t_frac(0, 130, 13);
    t_frac(1, 4, 32);
    t_group(0, 1'b0, 16, "R6 group 16x");
    t_group(1, 1'b0, 8, "R6 group 8x");
    t_group(2, 1'b0, 3, "R6 group 3x");
    t_group(3, 1'b0, 16, "R6 group reserved code");
    t_group(2, 1'b1, 8, "R7 3x promoted to 8x");
    t_latch();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule